// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns an addressing-mode code, up to two operand bytes and a snapshot of the DE pair, the HL pair and the stack pointer into one 16-bit memory address for a small 8-bit controller. A command carries the mode, a one-bit qualifier and the register values. The operand bytes follow on a separate byte stream, and each mode consumes exactly as many bytes as it needs. The finished address is offered on a result stream, together with a range-error flag and the stack pointer value that the access leaves behind.

The unit handles one request at a time. A command is taken only while the unit is idle. Bytes are taken only while a command is collecting. The result stays on the output until the consumer takes it. On every stream the sender keeps valid and its data steady until the matching ready is seen high at a clock edge. The consumer may hold `ea_ready` low for as long as it likes, and the result then waits unchanged. The register values are sampled when the command is accepted, so the source may change them afterwards.

Mode codes on `cmd_mode`: 0 direct, 1 short direct, 2 special-register page, 3 register indirect, 4 based, 5 stack. Codes 6 and 7 are reserved.

Top module: `opnd_addr_gen`

## Requirements
- R1: Mode 0 takes two bytes. The first byte received is the low half of the address and the second is the high half. The range-error flag stays 0.
- R2: Mode 1 takes one offset byte, which gives address bits 7..0. Address bits 15..9 are all ones. Bit 8 is 1 when the offset is below 20H and 0 otherwise. Every result therefore lies in FE20H..FF1FH.
- R3: In mode 1 with `cmd_sel`=1 (word operand), an odd offset raises the range-error flag and an even one does not. With `cmd_sel`=0, mode 1 never raises the flag.
- R4: Mode 2 takes one byte and yields FF00H plus that byte. The range-error flag is 1 exactly when the byte is D0H..DFH.
- R5: Mode 3 takes no bytes. It yields DE when `cmd_sel`=0 and HL when `cmd_sel`=1, with the range-error flag at 0.
- R6: Mode 4 takes one byte. It yields HL plus the zero-extended byte, modulo 2^16, with the range-error flag at 0.
- R7: Mode 5 takes no bytes. With `cmd_sel`=0 (push), both the address and the next pointer are SP-1. With `cmd_sel`=1 (pop), the address is SP and the next pointer is SP+1. The range-error flag is 1 when the address lies outside FE20H..FEFFH. In every other mode `ea_sp_next` equals the SP that was sampled.
- R8: Codes 6 and 7 take no bytes. They yield address 0000H with the range-error flag at 1.
- R9: `cmd_ready` is high only when the unit is idle, and `byte_ready` is high only while operand bytes are still owed. A byte offered at any other time is not consumed and does not affect any result.
- R10: `ea_valid` rises one cycle after the handshake that completes the request: the last byte, or the command itself for modes that take no bytes. The result stays unchanged while `ea_ready` is low. `cmd_ready` returns in the cycle after `ea_ready` is seen.
- R11: During and after reset, `ea_valid` and `byte_ready` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| cmd_mode | input | 3 | Addressing mode code |
| cmd_sel | input | 1 | Qualifier: pair select, word operand, or pop |
| de_val | input | 16 | DE pair, sampled on command acceptance |
| hl_val | input | 16 | HL pair, sampled on command acceptance |
| sp_val | input | 16 | Stack pointer, sampled on command acceptance |
| byte_valid | input | 1 | Operand byte offered |
| byte_ready | output | 1 | Operand byte will be taken |
| byte_data | input | 8 | Operand byte, in fetch order |
| ea_valid | output | 1 | Result available |
| ea_ready | input | 1 | Consumer takes result |
| ea_addr | output | 16 | Effective address |
| ea_range_err | output | 1 | Address outside the mode's legal region |
| ea_sp_next | output | 16 | Stack pointer after the access |

## Verification
A stale byte-slot index or byte count would assemble the wrong operand or swap the direct-address halves. It would also leave `byte_ready` asserted too long or too briefly, so the fault shows on the very next request, either at the byte handshake or in the first `ea_addr`. A corrupted state or snapshot register would show up as a late or missing `ea_valid`, a result that drifts while `ea_ready` is held low, or an address built from values the source changed after the command was accepted. Each of these shows within a few cycles of the request. The sweeps cover every offset byte in the page-folded and register-page modes and every SP around the stack window.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
  localparam int ADDR_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int MAX_OPND  = 2;
  localparam int NEED_W    = $clog2(MAX_OPND + 1);

  typedef enum logic [2:0] {
    AM_DIRECT = 3'd0,
    AM_SHORT  = 3'd1,
    AM_SFR    = 3'd2,
    AM_INDIR  = 3'd3,
    AM_BASED  = 3'd4,
    AM_STACK  = 3'd5,
    AM_RSV6   = 3'd6,
    AM_RSV7   = 3'd7
  } am_e;

  // Operand bytes each mode consumes from the byte stream
  function automatic logic [NEED_W-1:0] bytes_needed(am_e m);
    case (m)
      AM_DIRECT: bytes_needed = NEED_W'(2);
      AM_SHORT,
      AM_SFR,
      AM_BASED:  bytes_needed = NEED_W'(1);
      default:   bytes_needed = NEED_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/opnd_byte_collector.sv
module opnd_byte_collector
  import opnd_ea_pkg::*;
#(
  parameter int MAX_BYTES = MAX_OPND,
  parameter int BW        = BYTE_W,
  localparam int CW       = $clog2(MAX_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [CW-1:0]         cmd_need,
  input  logic                  byte_valid,
  output logic                  byte_ready,
  input  logic [BW-1:0]         byte_data,
  input  logic                  res_ready,
  output logic                  res_valid,
  output logic                  cmd_fire,
  output logic                  fire,
  output logic [MAX_BYTES*BW-1:0] bytes_next
);
  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_HOLD} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, need_q;
  logic          byte_fire, last_byte;

  assign cmd_ready  = (st_q == S_IDLE);
  assign byte_ready = (st_q == S_COLLECT);
  assign res_valid  = (st_q == S_HOLD);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign byte_fire  = byte_valid && byte_ready;
  assign last_byte  = byte_fire && (CW'(cnt_q + 1'b1) == need_q);
  assign fire       = (cmd_fire && (cmd_need == '0)) || last_byte;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:    if (cmd_fire) st_d = (cmd_need == '0) ? S_HOLD : S_COLLECT;
      S_COLLECT: if (last_byte) st_d = S_HOLD;
      S_HOLD:    if (res_ready) st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      need_q <= '0;
    end else begin
      st_q <= st_d;
      if (cmd_fire) begin
        cnt_q  <= '0;
        need_q <= cmd_need;
      end else if (byte_fire) begin
        cnt_q <= CW'(cnt_q + 1'b1);
      end
    end
  end

  // One slot per operand byte; the byte arriving now bypasses its slot
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_slot
    logic [BW-1:0] slot_q;
    logic          hit;
    assign hit = byte_fire && (cnt_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q <= '0;
      else if (hit) slot_q <= byte_data;
    end
    assign bytes_next[i*BW +: BW] = hit ? byte_data : slot_q;
  end

  p_cnt_below_need_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (cnt_q < need_q));
  p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);
  p_zero_byte_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_need == '0) |=> res_valid);
  p_idle_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> cmd_ready);
endmodule

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
  import opnd_ea_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SHORT_BASE = 16'hFE20,
  parameter logic [BYTE_W-1:0] SFR_PAGE   = 8'hFF
) (
  input  am_e               mode,
  input  logic              sel,
  input  logic [BYTE_W-1:0] b_lo,
  input  logic [BYTE_W-1:0] b_hi,
  input  logic [ADDR_W-1:0] de,
  input  logic [ADDR_W-1:0] hl,
  input  logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sp_next
);
  localparam logic [BYTE_W-1:0] SPLIT    = SHORT_BASE[BYTE_W-1:0];
  localparam logic [BYTE_W-1:0] PAGE_LO  = SHORT_BASE[ADDR_W-1:BYTE_W];
  localparam logic [BYTE_W-1:0] PAGE_HI  = BYTE_W'(PAGE_LO + 1'b1);

  logic [ADDR_W-1:0] sp_dec, sp_inc;
  assign sp_dec = ADDR_W'(sp - 1'b1);
  assign sp_inc = ADDR_W'(sp + 1'b1);

  always_comb begin
    addr    = '0;
    sp_next = sp;
    case (mode)
      AM_DIRECT: addr = {b_hi, b_lo};
      // Window folds across a page: offsets below the split land one page up
      AM_SHORT:  addr = (b_lo < SPLIT) ? {PAGE_HI, b_lo} : {PAGE_LO, b_lo};
      AM_SFR:    addr = {SFR_PAGE, b_lo};
      AM_INDIR:  addr = sel ? hl : de;
      AM_BASED:  addr = ADDR_W'(hl + {{(ADDR_W-BYTE_W){1'b0}}, b_lo});
      AM_STACK: begin
        addr    = sel ? sp : sp_dec;
        sp_next = sel ? sp_inc : sp_dec;
      end
      default:   addr = '0;
    endcase
  end
endmodule

// File: rtl/opnd_ea_check.sv
module opnd_ea_check
  import opnd_ea_pkg::*;
#(
  parameter logic [BYTE_W-1:0] HOLE_LO = 8'hD0,
  parameter logic [BYTE_W-1:0] HOLE_HI = 8'hDF,
  parameter logic [ADDR_W-1:0] RAM_LO  = 16'hFE20,
  parameter logic [ADDR_W-1:0] RAM_HI  = 16'hFEFF
) (
  input  am_e               mode,
  input  logic              sel,
  input  logic [BYTE_W-1:0] b_lo,
  input  logic [ADDR_W-1:0] addr,
  output logic              err
);
  always_comb begin
    case (mode)
      AM_SHORT: err = sel && b_lo[0];
      AM_SFR:   err = (b_lo >= HOLE_LO) && (b_lo <= HOLE_HI);
      AM_STACK: err = (addr < RAM_LO) || (addr > RAM_HI);
      AM_RSV6,
      AM_RSV7:  err = 1'b1;
      default:  err = 1'b0;
    endcase
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_ea_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SHORT_BASE = 16'hFE20,
  parameter logic [BYTE_W-1:0] SFR_PAGE   = 8'hFF,
  parameter logic [BYTE_W-1:0] HOLE_LO    = 8'hD0,
  parameter logic [BYTE_W-1:0] HOLE_HI    = 8'hDF,
  parameter logic [ADDR_W-1:0] RAM_LO     = 16'hFE20,
  parameter logic [ADDR_W-1:0] RAM_HI     = 16'hFEFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_mode,
  input  logic              cmd_sel,
  input  logic [ADDR_W-1:0] de_val,
  input  logic [ADDR_W-1:0] hl_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              ea_valid,
  input  logic              ea_ready,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_range_err,
  output logic [ADDR_W-1:0] ea_sp_next
);
  localparam logic [ADDR_W-1:0] SHORT_TOP = ADDR_W'(SHORT_BASE + 16'd255);

  am_e               mode_in, mode_q, mode_now;
  logic              sel_q, sel_now;
  logic [ADDR_W-1:0] de_q, hl_q, sp_q, de_now, hl_now, sp_now;
  logic              cmd_fire, fire;
  logic [MAX_OPND*BYTE_W-1:0] bytes_next;
  logic [ADDR_W-1:0] addr_c, spn_c;
  logic              err_c;

  assign mode_in = am_e'(cmd_mode);

  opnd_byte_collector #(.MAX_BYTES(MAX_OPND), .BW(BYTE_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_need   (bytes_needed(mode_in)),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .byte_data  (byte_data),
    .res_ready  (ea_ready),
    .res_valid  (ea_valid),
    .cmd_fire   (cmd_fire),
    .fire       (fire),
    .bytes_next (bytes_next)
  );

  // Context snapshot: taken at command acceptance, bypassed in that same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_DIRECT;
      sel_q  <= 1'b0;
      de_q   <= '0;
      hl_q   <= '0;
      sp_q   <= '0;
    end else if (cmd_fire) begin
      mode_q <= mode_in;
      sel_q  <= cmd_sel;
      de_q   <= de_val;
      hl_q   <= hl_val;
      sp_q   <= sp_val;
    end
  end

  assign mode_now = cmd_fire ? mode_in : mode_q;
  assign sel_now  = cmd_fire ? cmd_sel : sel_q;
  assign de_now   = cmd_fire ? de_val  : de_q;
  assign hl_now   = cmd_fire ? hl_val  : hl_q;
  assign sp_now   = cmd_fire ? sp_val  : sp_q;

  opnd_ea_calc #(.SHORT_BASE(SHORT_BASE), .SFR_PAGE(SFR_PAGE)) u_calc (
    .mode    (mode_now),
    .sel     (sel_now),
    .b_lo    (bytes_next[BYTE_W-1:0]),
    .b_hi    (bytes_next[2*BYTE_W-1:BYTE_W]),
    .de      (de_now),
    .hl      (hl_now),
    .sp      (sp_now),
    .addr    (addr_c),
    .sp_next (spn_c)
  );

  opnd_ea_check #(.HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI),
                  .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) u_check (
    .mode (mode_now),
    .sel  (sel_now),
    .b_lo (bytes_next[BYTE_W-1:0]),
    .addr (addr_c),
    .err  (err_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_addr      <= '0;
      ea_range_err <= 1'b0;
      ea_sp_next   <= '0;
    end else if (fire) begin
      ea_addr      <= addr_c;
      ea_range_err <= err_c;
      ea_sp_next   <= spn_c;
    end
  end

  p_short_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && mode_q == AM_SHORT) |-> (ea_addr >= SHORT_BASE && ea_addr <= SHORT_TOP));
  p_sfr_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && mode_q == AM_SFR) |-> (ea_addr[ADDR_W-1:BYTE_W] == SFR_PAGE));
  p_indir_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && mode_q == AM_INDIR) |-> !ea_range_err);
  p_push_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && mode_q == AM_STACK && !sel_q) |-> (ea_sp_next == ea_addr));
  p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && mode_q == AM_STACK && sel_q) |-> (ea_sp_next == ADDR_W'(ea_addr + 1'b1)));
  p_rsv_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && (mode_q == AM_RSV6 || mode_q == AM_RSV7)) |-> (ea_range_err && ea_addr == '0));
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !ea_ready) |=> ($stable(ea_addr) && $stable(ea_range_err) && $stable(ea_sp_next)));
endmodule

// File: tb/opnd_addr_gen_tb_top.sv
module opnd_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_sel = 1'b0;
  logic [2:0]  cmd_mode = '0;
  logic [15:0] de_val = '0, hl_val = '0, sp_val = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        ea_ready = 1'b0;
  logic        cmd_ready, byte_ready, ea_valid, ea_range_err;
  logic [15:0] ea_addr, ea_sp_next;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  always #4 clk = ~clk;

  opnd_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_sel(cmd_sel), .de_val(de_val), .hl_val(hl_val),
    .sp_val(sp_val), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .ea_valid(ea_valid), .ea_ready(ea_ready),
    .ea_addr(ea_addr), .ea_range_err(ea_range_err), .ea_sp_next(ea_sp_next)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int need_of(int m);
    if (m == 0) return 2;
    if (m == 1 || m == 2 || m == 4) return 1;
    return 0;
  endfunction

  // One full request; expected values derived from the requirement text
  task automatic run(int m, bit s, logic [7:0] b0, logic [7:0] b1,
                     logic [15:0] de, logic [15:0] hl, logic [15:0] sp,
                     int hold, string req);
    logic [15:0] ea, esp;
    logic        eerr;
    esp  = sp;
    eerr = 1'b0;
    case (m)
      0: ea = {b1, b0};
      1: begin ea = (b0 < 8'h20) ? {8'hFF, b0} : {8'hFE, b0}; eerr = s && b0[0]; end
      2: begin ea = {8'hFF, b0}; eerr = (b0 >= 8'hD0 && b0 <= 8'hDF); end
      3: ea = s ? hl : de;
      4: ea = hl + {8'h00, b0};
      5: begin
        ea  = s ? sp : sp - 16'd1;
        esp = s ? sp + 16'd1 : sp - 16'd1;
        eerr = (ea < 16'hFE20) || (ea > 16'hFEFF);
      end
      default: begin ea = 16'h0000; eerr = 1'b1; end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 3'(m); cmd_sel = s;
    de_val = de; hl_val = hl; sp_val = sp;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    de_val = ~de; hl_val = ~hl; sp_val = ~sp;   // must not leak into result
    for (int i = 0; i < need_of(m); i++) begin
      byte_valid = 1'b1;
      byte_data  = (i == 0) ? b0 : b1;
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
    end
    byte_valid = 1'b0;
    chk({req, " R10 valid one cycle after completion"}, ea_valid, 1);
    chk({req, " R9 no bytes owed"}, byte_ready, 0);
    repeat (hold) @(negedge clk);
    chk({req, " R10 valid held"}, ea_valid, 1);
    chk({req, " addr"}, ea_addr, ea);
    chk({req, " range_err"}, ea_range_err, eerr);
    chk({req, " R7 sp_next"}, ea_sp_next, esp);
    ea_ready = 1'b1;
    @(negedge clk);
    ea_ready = 1'b0;
    chk({req, " R10 cmd_ready back"}, cmd_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 ea_valid in reset", ea_valid, 0);
    chk("R11 cmd_ready in reset", cmd_ready, 1);
    chk("R11 byte_ready in reset", byte_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ea_valid after reset", ea_valid, 0);

    // R9: stray byte while idle is neither taken nor used
    byte_valid = 1'b1; byte_data = 8'hA5;
    @(negedge clk);
    chk("R9 byte_ready low when idle", byte_ready, 0);
    byte_valid = 1'b0;
    run(0, 0, 8'h00, 8'hFE, 16'h0, 16'h0, 16'h0, 0, "R9 R1 after stray byte");

    for (int k = 0; k < 40; k++)
      run(0, k[0], 8'(k * 37 + 5), 8'(k * 91 + 3), 16'h1111, 16'h2222, 16'h3333, k % 3, "R1 direct");
    for (int o = 0; o < 256; o++) begin
      run(1, 0, 8'(o), 8'h00, 16'h0, 16'h0, 16'hFE80, 0, "R2 short");
      run(1, 1, 8'(o), 8'h00, 16'h0, 16'h0, 16'hFE80, 0, "R3 short word");
      run(2, 0, 8'(o), 8'h00, 16'h0, 16'h0, 16'hFE80, 0, "R4 sfr");
    end
    for (int k = 0; k < 20; k++) begin
      run(3, 0, 8'h00, 8'h00, 16'(k * 3001 + 7), 16'(k * 1777 + 9), 16'hFE40, k % 2, "R5 indirect DE");
      run(3, 1, 8'h00, 8'h00, 16'(k * 3001 + 7), 16'(k * 1777 + 9), 16'hFE40, 0, "R5 indirect HL");
    end
    for (int h = 0; h < 4; h++) begin
      logic [15:0] hv;
      hv = (h == 0) ? 16'h0000 : (h == 1) ? 16'hFFFF : (h == 2) ? 16'hFF80 : 16'h1234;
      for (int o = 0; o < 256; o++)
        run(4, 0, 8'(o), 8'h00, 16'h0, hv, 16'h0, 0, "R6 based");
    end
    for (int sp = 16'hFE00; sp <= 16'hFF40; sp++) begin
      run(5, 0, 8'h00, 8'h00, 16'h0, 16'h0, 16'(sp), 0, "R7 push");
      run(5, 1, 8'h00, 8'h00, 16'h0, 16'h0, 16'(sp), 0, "R7 pop");
    end
    run(5, 0, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0000, 0, "R7 push wrap");
    run(5, 1, 8'h00, 8'h00, 16'h0, 16'h0, 16'hFFFF, 0, "R7 pop wrap");
    run(6, 0, 8'h00, 8'h00, 16'h1, 16'h2, 16'hFE50, 2, "R8 reserved 6");
    run(7, 1, 8'h00, 8'h00, 16'h1, 16'h2, 16'hFE50, 0, "R8 reserved 7");
    run(1, 1, 8'h1F, 8'h00, 16'h0, 16'h0, 16'h0, 4, "R10 R3 held result");

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule